// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls fixed 16-byte command entries out of a circular buffer in memory. Software programs a 4 KiB-aligned base page and a ring size, then moves a tail offset forward as it produces commands. The engine consumes entries at the head offset. Each entry is read through a memory request/response port, one entry at a time. The opcode nibble of each entry is decoded. A recognised command goes to a downstream consumer over a valid/ready handshake.

Fetching runs only while the running status bit is set. That bit is set or cleared when software changes the ring-enable bit, and the new value depends on the global enable bit in the same write. The engine clears the bit itself on an unrecognised opcode or on a memory read error. Software restarts the ring by turning the ring-enable bit off and on again. A pending-entry count is derived continuously from head, tail and ring size. A sticky event-log overflow bit is also held here, and it is cleared by arming event logging.

Top module: `cmdring_engine`

## Requirements
- R1: After reset the control value, head, tail, pending count, running bit and overflow bit are all zero, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: Register select 0 writes the control value, 1 the base, 2 the head and 3 the tail. A control write keeps only the bits set in 0x004defffffffffff.
- R3: A control write that changes bit 12 (ring enable) sets running exactly when bits 0 (global enable) and 12 are both 1 in the written value, and clears it otherwise. A control write that leaves bit 12 unchanged does not alter running.
- R4: The base write holds the page number in bits [39:0] and the ring-size code in bits [43:40]. The ring holds 2^code entries, and a code above MAX_LOG2 is treated as MAX_LOG2. `pending_cnt` equals tail index minus head index when tail ≥ head, and otherwise equals the entry count minus head plus tail, where index = offset >> 4.
- R5: Each memory request address is the base page shifted left by 12 plus the current head byte offset.
- R6: Head and tail writes clear offset bits [3:0]. After each error-free response the head becomes (fetched offset + 16) modulo the ring size in bytes, so it wraps to 0 past the last entry.
- R7: A fetch starts only when running is 1 and head differs from tail. Fetching repeats until they are equal. A later head or tail write, or a ring-enable change, starts or stops fetching again.
- R8: The opcode sits in entry bits [63:60]. Codes 1 through 8 (completion wait, invalidate device entry, invalidate pages, invalidate remote-TLB pages, invalidate interrupt table, prefetch pages, complete page request, invalidate all) are handed out whole and in ring order on `cmd_data`. `cmd_valid` and `cmd_data` hold until `cmd_ready`.
- R9: Opcode 0 or 9 to 15 is not handed out. The head still advances past that entry, running is cleared and no further fetch is issued.
- R10: A response with `mem_rsp_err` set clears running, leaves the head unchanged and hands nothing out.
- R11: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. Only one request is outstanding at a time.
- R12: A pulse on `evlog_ovf_set` sets the overflow bit. A control write that changes bit 2 (event-log enable) clears the bit only when bits 0 and 2 are both 1 in the written value. Otherwise the bit is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 base, 2 head, 3 tail |
| reg_wdata | input | 64 | Register write data |
| evlog_ovf_set | input | 1 | Sets the event-log overflow status bit |
| ctrl_q | output | 64 | Current control value |
| status_running | output | 1 | Running status bit |
| status_evlog_ovf | output | 1 | Event-log overflow status bit |
| head_off | output | MAX_LOG2+4 | Head byte offset |
| tail_off | output | MAX_LOG2+4 | Tail byte offset |
| pending_cnt | output | MAX_LOG2+1 | Entries between head and tail |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | BASE_W+12 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read response valid |
| mem_rsp_err | input | 1 | Memory read response carries an error |
| mem_rsp_data | input | 128 | Entry read from memory |
| cmd_valid | output | 1 | Command available to the consumer |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 128 | Command entry |

## Verification
The bench builds the engine with MAX_LOG2 = 3, so the largest ring has eight entries. At that size every head/tail pair for every ring-size code can be swept, including codes above the limit that must clamp. Small rings also make wrap-around happen within a few commands. The bench places every illegal opcode value in turn at the head, and it injects a read error on a chosen entry. Memory and consumer ready signals toggle on different periods, so both handshakes are held under back-pressure many times.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

  localparam int ENTRY_SHIFT = 4;
  localparam int PAGE_SHIFT  = 12;
  localparam logic [63:0] CTRL_KEEP = 64'h004d_efff_ffff_ffff;

  localparam int CTL_GLOBAL_EN = 0;
  localparam int CTL_EVLOG_EN  = 2;
  localparam int CTL_RING_EN   = 12;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_HEAD = 2'd2,
    REG_TAIL = 2'd3
  } reg_sel_e;

  typedef enum logic [3:0] {
    OP_CWAIT     = 4'd1,
    OP_INV_DEV   = 4'd2,
    OP_INV_PAGES = 4'd3,
    OP_INV_RTLB  = 4'd4,
    OP_INV_INTR  = 4'd5,
    OP_PREFETCH  = 4'd6,
    OP_PRQ_DONE  = 4'd7,
    OP_INV_ALL   = 4'd8
  } opcode_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_DISP
  } fetch_state_e;

  // ring size in bytes for a size code
  function automatic int unsigned ring_bytes(int unsigned len_code);
    return 32'd16 << len_code;
  endfunction

  // byte offset of the entry after 'off', wrapping at the ring end
  function automatic int unsigned ring_next(int unsigned off, int unsigned len_code);
    return (off + 32'd16) & (ring_bytes(len_code) - 32'd1);
  endfunction

  // number of entries from head up to (not including) tail
  function automatic int unsigned ring_pending(int unsigned head, int unsigned tail,
                                               int unsigned len_code);
    int unsigned hi;
    int unsigned ti;
    hi = head >> ENTRY_SHIFT;
    ti = tail >> ENTRY_SHIFT;
    if (ti >= hi) return ti - hi;
    return (32'd1 << len_code) - hi + ti;
  endfunction

  function automatic logic op_known(logic [3:0] op);
    return (op >= 4'(OP_CWAIT)) && (op <= 4'(OP_INV_ALL));
  endfunction

endpackage

// File: rtl/cmdring_decode.sv
module cmdring_decode
  import cmdring_pkg::*;
(
  input  logic [3:0] opcode,
  output logic       known
);
  assign known = op_known(opcode);
endmodule

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter  int MAX_LOG2 = 15,
  parameter  int BASE_W   = 40,
  parameter  int LEN_W    = 4,
  localparam int OFF_W    = MAX_LOG2 + ENTRY_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  input  logic              ovf_set,
  input  logic              halt,
  input  logic              head_adv,
  input  logic [OFF_W-1:0]  head_adv_val,
  output logic [63:0]       ctrl,
  output logic [BASE_W-1:0] base_page,
  output logic [LEN_W-1:0]  len_eff,
  output logic [OFF_W-1:0]  head,
  output logic [OFF_W-1:0]  tail,
  output logic              running,
  output logic              ovf
);
  logic [LEN_W-1:0] len_raw;
  logic [63:0]      ctrl_new;
  logic             ctrl_wr, base_wr, head_wr, tail_wr;
  logic             ring_flip, evlog_arm;
  logic [OFF_W-1:0] wr_off;

  assign ctrl_wr  = reg_we && (reg_sel == 2'(REG_CTRL));
  assign base_wr  = reg_we && (reg_sel == 2'(REG_BASE));
  assign head_wr  = reg_we && (reg_sel == 2'(REG_HEAD));
  assign tail_wr  = reg_we && (reg_sel == 2'(REG_TAIL));
  assign ctrl_new = reg_wdata & CTRL_KEEP;
  assign wr_off   = {reg_wdata[OFF_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};

  assign ring_flip = ctrl_wr && (ctrl_new[CTL_RING_EN] != ctrl[CTL_RING_EN]);
  assign evlog_arm = ctrl_wr && (ctrl_new[CTL_EVLOG_EN] != ctrl[CTL_EVLOG_EN])
                     && ctrl_new[CTL_GLOBAL_EN] && ctrl_new[CTL_EVLOG_EN];

  assign len_eff = (32'(len_raw) > MAX_LOG2) ? LEN_W'(MAX_LOG2) : len_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      base_page <= '0;
      len_raw   <= '0;
      head      <= '0;
      tail      <= '0;
      running   <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_new;
      if (base_wr) begin
        base_page <= reg_wdata[BASE_W-1:0];
        len_raw   <= reg_wdata[BASE_W +: LEN_W];
      end
      // software write takes precedence over the engine's own advance
      if (head_wr)       head <= wr_off;
      else if (head_adv) head <= head_adv_val;
      if (tail_wr) tail <= wr_off;
      // ring-enable edge decides; otherwise a fault or illegal opcode stops
      if (ring_flip) running <= ctrl_new[CTL_GLOBAL_EN] & ctrl_new[CTL_RING_EN];
      else if (halt) running <= 1'b0;
      if (ovf_set)        ovf <= 1'b1;
      else if (evlog_arm) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdring_fetch_fsm.sv
module cmdring_fetch_fsm
  import cmdring_pkg::*;
#(
  parameter  int MAX_LOG2 = 15,
  parameter  int BASE_W   = 40,
  parameter  int LEN_W    = 4,
  parameter  int ENTRY_W  = 128,
  localparam int OFF_W    = MAX_LOG2 + ENTRY_SHIFT,
  localparam int ADDR_W   = BASE_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               running,
  input  logic [BASE_W-1:0]  base_page,
  input  logic [LEN_W-1:0]   len_eff,
  input  logic [OFF_W-1:0]   head,
  input  logic [OFF_W-1:0]   tail,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  input  logic               rsp_known,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ENTRY_W-1:0] cmd_data,
  output logic               fetch_go,
  output logic               rsp_fault,
  output logic               illegal_hit,
  output logic               head_adv,
  output logic [OFF_W-1:0]   head_adv_val
);
  fetch_state_e       state;
  logic [ADDR_W-1:0]  req_addr;
  logic [OFF_W-1:0]   fetch_off;
  logic [ENTRY_W-1:0] cmd_q;
  logic               rsp_take;

  assign fetch_go     = (state == F_IDLE) && running && (head != tail);
  assign rsp_take     = (state == F_WAIT) && mem_rsp_valid;
  assign rsp_fault    = rsp_take && mem_rsp_err;
  assign head_adv     = rsp_take && !mem_rsp_err;
  assign illegal_hit  = head_adv && !rsp_known;
  assign head_adv_val = OFF_W'(ring_next(32'(fetch_off), 32'(len_eff)));

  assign mem_req_valid = (state == F_REQ);
  assign mem_req_addr  = req_addr;
  assign cmd_valid     = (state == F_DISP);
  assign cmd_data      = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= F_IDLE;
      req_addr  <= '0;
      fetch_off <= '0;
      cmd_q     <= '0;
    end else begin
      case (state)
        F_IDLE: if (fetch_go) begin
          state     <= F_REQ;
          req_addr  <= {base_page, {PAGE_SHIFT{1'b0}}} + ADDR_W'(head);
          fetch_off <= head;
        end
        F_REQ: if (mem_req_ready) state <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err || !rsp_known) state <= F_IDLE;
          else begin
            state <= F_DISP;
            cmd_q <= mem_rsp_data;
          end
        end
        F_DISP: if (cmd_ready) state <= F_IDLE;
        default: state <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
  import cmdring_pkg::*;
#(
  parameter  int MAX_LOG2 = 15,
  parameter  int BASE_W   = 40,
  parameter  int LEN_W    = 4,
  parameter  int ENTRY_W  = 128,
  localparam int OFF_W    = MAX_LOG2 + ENTRY_SHIFT,
  localparam int IDX_W    = MAX_LOG2 + 1,
  localparam int ADDR_W   = BASE_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [63:0]        reg_wdata,
  input  logic               evlog_ovf_set,
  output logic [63:0]        ctrl_q,
  output logic               status_running,
  output logic               status_evlog_ovf,
  output logic [OFF_W-1:0]   head_off,
  output logic [OFF_W-1:0]   tail_off,
  output logic [IDX_W-1:0]   pending_cnt,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ENTRY_W-1:0] cmd_data
);
  logic [BASE_W-1:0] base_page;
  logic [LEN_W-1:0]  len_eff;
  logic              rsp_known;
  logic              fetch_go, rsp_fault, illegal_hit, head_adv, halt;
  logic [OFF_W-1:0]  head_adv_val;

  assign halt        = rsp_fault | illegal_hit;
  assign pending_cnt = IDX_W'(ring_pending(32'(head_off), 32'(tail_off), 32'(len_eff)));

  cmdring_regs #(.MAX_LOG2(MAX_LOG2), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ovf_set(evlog_ovf_set), .halt(halt),
    .head_adv(head_adv), .head_adv_val(head_adv_val),
    .ctrl(ctrl_q), .base_page(base_page), .len_eff(len_eff),
    .head(head_off), .tail(tail_off),
    .running(status_running), .ovf(status_evlog_ovf)
  );

  cmdring_decode u_dec (
    .opcode(mem_rsp_data[63:60]),
    .known(rsp_known)
  );

  cmdring_fetch_fsm #(.MAX_LOG2(MAX_LOG2), .BASE_W(BASE_W), .LEN_W(LEN_W),
                      .ENTRY_W(ENTRY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .running(status_running), .base_page(base_page), .len_eff(len_eff),
    .head(head_off), .tail(tail_off),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data), .rsp_known(rsp_known),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .fetch_go(fetch_go), .rsp_fault(rsp_fault), .illegal_hit(illegal_hit),
    .head_adv(head_adv), .head_adv_val(head_adv_val)
  );
endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk #(
  parameter  int MAX_LOG2 = 15,
  parameter  int BASE_W   = 40,
  parameter  int ENTRY_W  = 128,
  localparam int OFF_W    = MAX_LOG2 + 4,
  localparam int IDX_W    = MAX_LOG2 + 1,
  localparam int ADDR_W   = BASE_W + 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic               status_running,
  input logic [OFF_W-1:0]   head_off,
  input logic [OFF_W-1:0]   tail_off,
  input logic [IDX_W-1:0]   pending_cnt,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [ENTRY_W-1:0] cmd_data,
  input logic               fetch_go,
  input logic               rsp_fault,
  input logic               illegal_hit
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R8
  cmd_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_data[63:60] >= 4'd1) && (cmd_data[63:60] <= 4'd8));

  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault && !reg_we |=> !status_running && (head_off == $past(head_off)));

  // R9
  illegal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_hit && !reg_we |=> !status_running && !cmd_valid);

  // R4
  empty_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_off == tail_off) |-> (pending_cnt == '0));

  // R7
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(status_running) && $past(head_off != tail_off));

  // R7
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> !mem_req_valid && !cmd_valid);
endmodule

bind cmdring_engine cmdring_chk #(.MAX_LOG2(MAX_LOG2), .BASE_W(BASE_W), .ENTRY_W(ENTRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .status_running(status_running), .head_off(head_off), .tail_off(tail_off),
  .pending_cnt(pending_cnt),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .fetch_go(fetch_go), .rsp_fault(rsp_fault), .illegal_hit(illegal_hit)
);

// File: tb/cmdring_engine_tb.sv
module cmdring_engine_tb;
  localparam int MAXL   = 3;
  localparam int OFF_W  = MAXL + 4;
  localparam int IDX_W  = MAXL + 1;
  localparam int ADDR_W = 52;
  localparam logic [63:0] EN  = 64'h1;
  localparam logic [63:0] EVL = 64'h4;
  localparam logic [63:0] BUF = 64'h1000;
  localparam logic [39:0] PAGE = 40'h12345;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [1:0] reg_sel;
  logic [63:0] reg_wdata;
  logic evlog_ovf_set;
  logic [63:0] ctrl_q;
  logic status_running, status_evlog_ovf;
  logic [OFF_W-1:0] head_off, tail_off;
  logic [IDX_W-1:0] pending_cnt;
  logic mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid, mem_rsp_err;
  logic [127:0] mem_rsp_data;
  logic cmd_valid, cmd_ready;
  logic [127:0] cmd_data;

  cmdring_engine #(.MAX_LOG2(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .evlog_ovf_set(evlog_ovf_set), .ctrl_q(ctrl_q), .status_running(status_running),
    .status_evlog_ovf(status_evlog_ovf), .head_off(head_off), .tail_off(tail_off),
    .pending_cnt(pending_cnt), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data)
  );

  initial forever #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] mem_op [0:7];
  bit mem_bad [0:7];
  logic [51:0] got_addr [0:63];
  logic [3:0] got_op [0:63];
  int n_got = 0;
  int n_req = 0;
  int hold_err_req = 0;
  int hold_err_cmd = 0;
  int ph = 0;
  bit rsp_pend = 1'b0;
  logic [51:0] rsp_addr;
  bit prev_req_wait = 1'b0;
  logic [51:0] prev_req_addr;
  bit prev_cmd_wait = 1'b0;
  logic [127:0] prev_cmd_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [63:0] offs(input int idx);
    return 64'((idx % 8) * 16);
  endfunction

  function automatic logic [51:0] eaddr(input int off);
    return {PAGE, 12'h000} + 52'(off);
  endfunction

  // memory model, consumer and handshake monitors (one process, negedge)
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    mem_rsp_data = '0; cmd_ready = 1'b0;
    forever begin
      @(negedge clk);
      ph++;
      if (rst_n) begin
        if (prev_req_wait && (!mem_req_valid || mem_req_addr !== prev_req_addr)) hold_err_req++;
        if (prev_cmd_wait && (!cmd_valid || cmd_data !== prev_cmd_data)) hold_err_cmd++;
      end
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = mem_bad[rsp_addr[6:4]];
        mem_rsp_data  = {~{12'h000, rsp_addr}, mem_op[rsp_addr[6:4]], 8'h00, rsp_addr};
        rsp_pend = 1'b0;
      end
      mem_req_ready = (ph % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        rsp_addr = mem_req_addr;
        rsp_pend = 1'b1;
        n_req++;
      end
      cmd_ready = (ph % 4) != 1;
      if (rst_n && cmd_valid && cmd_ready && n_got < 64) begin
        got_addr[n_got] = cmd_data[51:0];
        got_op[n_got]   = cmd_data[63:60];
        n_got++;
      end
      prev_req_wait = mem_req_valid && !mem_req_ready;
      prev_req_addr = mem_req_addr;
      prev_cmd_wait = cmd_valid && !cmd_ready;
      prev_cmd_data = cmd_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int g0, r0, h, hh, g1, r1;
    int ill [8];
    ill = '{0, 9, 10, 11, 12, 13, 14, 15};
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; evlog_ovf_set = 1'b0;
    for (int i = 0; i < 8; i++) begin mem_op[i] = 4'(i + 1); mem_bad[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 running", 64'(status_running), 0);
    chk("R1 ovf", 64'(status_evlog_ovf), 0);
    chk("R1 head", 64'(head_off), 0);
    chk("R1 tail", 64'(tail_off), 0);
    chk("R1 pending", 64'(pending_cnt), 0);
    chk("R1 req", 64'(mem_req_valid), 0);
    chk("R1 cmd", 64'(cmd_valid), 0);

    // R2 mask, R3 running rule
    wr(2'd0, '1);
    chk("R2 ctrl mask", ctrl_q, 64'h004d_efff_ffff_ffff);
    chk("R3 both set", 64'(status_running), 1);
    wr(2'd0, 0);
    chk("R3 ring off", 64'(status_running), 0);
    wr(2'd0, BUF);
    chk("R3 ring on no global", 64'(status_running), 0);
    wr(2'd0, BUF | EN);
    chk("R3 ring unchanged", 64'(status_running), 0);
    wr(2'd0, EN);
    wr(2'd0, EN | BUF);
    chk("R3 ring edge with global", 64'(status_running), 1);
    wr(2'd0, BUF);
    chk("R3 global drop keeps", 64'(status_running), 1);
    wr(2'd0, 0);
    chk("R3 ring off again", 64'(status_running), 0);

    // R4 pending sweep for every size code (codes above MAXL clamp)
    for (int l = 0; l <= MAXL + 2; l++) begin
      int le;
      le = (l > MAXL) ? MAXL : l;
      wr(2'd1, {20'd0, 4'(l), PAGE});
      for (int hi = 0; hi < (1 << le); hi++)
        for (int ti = 0; ti < (1 << le); ti++) begin
          int ex;
          wr(2'd2, 64'(hi * 16));
          wr(2'd3, 64'(ti * 16));
          ex = (ti >= hi) ? ti - hi : (1 << le) - hi + ti;
          chk("R4 pending", 64'(pending_cnt), 64'(ex));
        end
    end

    // R6 offset alignment on write
    wr(2'd2, 64'(16 * 3 + 5));
    chk("R6 head align", 64'(head_off), 48);

    // R5 R6 R7 R8 wrapped run of five commands, size code 3
    wr(2'd1, {20'd0, 4'd3, PAGE});
    wr(2'd2, 80);
    wr(2'd3, 32);
    g0 = n_got; r0 = n_req;
    wr(2'd0, EN | BUF);
    repeat (150) @(negedge clk);
    chk("R7 count", 64'(n_got - g0), 5);
    for (int k = 0; k < 5; k++) begin
      chk("R5 addr", 64'(got_addr[g0 + k]), 64'(eaddr((5 + k) % 8 * 16)));
      chk("R8 opcode", 64'(got_op[g0 + k]), 64'(((5 + k) % 8) + 1));
    end
    chk("R6 head wrapped", 64'(head_off), 32);
    chk("R7 pending 0", 64'(pending_cnt), 0);
    chk("R7 still running", 64'(status_running), 1);
    chk("R11 one req each", 64'(n_req - r0), 5);

    // R7 stop, then restart by ring enable and by tail write
    wr(2'd0, EN);
    chk("R3 ring clear", 64'(status_running), 0);
    wr(2'd3, 96);
    repeat (30) @(negedge clk);
    chk("R7 no fetch when stopped", 64'(n_req - r0), 5);
    chk("R7 head kept", 64'(head_off), 32);
    chk("R4 pending 4", 64'(pending_cnt), 4);
    wr(2'd0, EN | BUF);
    repeat (100) @(negedge clk);
    chk("R7 resume head", 64'(head_off), 96);
    chk("R7 resume count", 64'(n_got - g0), 9);
    wr(2'd3, 112);
    repeat (40) @(negedge clk);
    chk("R7 tail write fetch", 64'(head_off), 112);
    chk("R7 tail write count", 64'(n_got - g0), 10);

    // R9 every illegal opcode value
    h = 7;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, EN);
      mem_op[h] = 4'(ill[i]);
      mem_op[(h + 1) % 8] = 4'd3;
      g1 = n_got;
      wr(2'd3, offs(h + 2));
      wr(2'd0, EN | BUF);
      repeat (60) @(negedge clk);
      chk("R9 running cleared", 64'(status_running), 0);
      chk("R9 head past illegal", 64'(head_off), offs(h + 1));
      chk("R9 nothing handed out", 64'(n_got - g1), 0);
      mem_op[h] = 4'd3;
      h = (h + 1) % 8;
    end
    wr(2'd0, EN);
    g1 = n_got;
    wr(2'd3, offs(h + 1));
    wr(2'd0, EN | BUF);
    repeat (40) @(negedge clk);
    chk("R9 restart count", 64'(n_got - g1), 1);
    chk("R9 restart head", 64'(head_off), offs(h + 1));

    // R10 read error
    hh = (h + 1) % 8;
    for (int i = 0; i < 3; i++) mem_op[(hh + i) % 8] = 4'd2;
    mem_bad[(hh + 1) % 8] = 1'b1;
    wr(2'd0, EN);
    g1 = n_got; r1 = n_req;
    wr(2'd3, offs(hh + 3));
    wr(2'd0, EN | BUF);
    repeat (60) @(negedge clk);
    chk("R10 running cleared", 64'(status_running), 0);
    chk("R10 head held", 64'(head_off), offs(hh + 1));
    chk("R10 dispatched", 64'(n_got - g1), 1);
    chk("R10 requests", 64'(n_req - r1), 2);
    mem_bad[(hh + 1) % 8] = 1'b0;
    wr(2'd0, EN);
    wr(2'd0, EN | BUF);
    repeat (60) @(negedge clk);
    chk("R10 retry head", 64'(head_off), offs(hh + 3));
    chk("R10 retry count", 64'(n_got - g1), 3);

    // R6 wrap on a four-entry ring
    wr(2'd0, EN);
    wr(2'd1, {20'd0, 4'd2, PAGE});
    mem_op[0] = 4'd4; mem_op[3] = 4'd5;
    wr(2'd2, 48);
    wr(2'd3, 16);
    g1 = n_got;
    wr(2'd0, EN | BUF);
    repeat (60) @(negedge clk);
    chk("R6 small count", 64'(n_got - g1), 2);
    chk("R6 small first", 64'(got_addr[g1]), 64'(eaddr(48)));
    chk("R6 small wrapped", 64'(got_addr[g1 + 1]), 64'(eaddr(0)));
    chk("R6 small head", 64'(head_off), 16);

    // R12 overflow bit
    wr(2'd0, 0);
    @(negedge clk); evlog_ovf_set = 1'b1;
    @(negedge clk); evlog_ovf_set = 1'b0;
    chk("R12 set", 64'(status_evlog_ovf), 1);
    wr(2'd0, EVL);
    chk("R12 no global keeps", 64'(status_evlog_ovf), 1);
    wr(2'd0, 0);
    wr(2'd0, EN | EVL);
    chk("R12 armed clears", 64'(status_evlog_ovf), 0);
    @(negedge clk); evlog_ovf_set = 1'b1;
    @(negedge clk); evlog_ovf_set = 1'b0;
    wr(2'd0, EN | EVL | BUF);
    chk("R12 unchanged bit keeps", 64'(status_evlog_ovf), 1);

    // R11 / R8 handshake holds over the whole run
    chk("R11 request held", 64'(hold_err_req), 0);
    chk("R8 command held", 64'(hold_err_cmd), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule